// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper Controller

This block sits between an 8-bit console CPU bus, the graphics chip's pattern bus and the memories on a game cartridge. It has one write-only control byte. The byte is loaded by any CPU write to the upper half of the CPU address space. The byte selects a switchable 16 KB program-ROM window at `$8000-$BFFF`, one of four 8 KB pattern-RAM banks, and a nametable mirroring arrangement. The window at `$C000-$FFFF` always shows the final program-ROM bank.

Two configuration inputs change how the control byte behaves: a board-variant code and the mirroring mode from the cartridge header. The variant code decides whether a write suffers a bus conflict. In a bus conflict the ROM drives the data bus during the write, so the byte that is latched is the CPU data ANDed with the ROM byte at that address. The variant code and the header mode together decide what the mirroring bit means. Address translation is combinational from the current register contents. The register changes only on a clock edge during a qualified write. The configuration inputs are treated as static while out of reset.

Top module: `bank_mapper_top`

## Requirements
- R1: A CPU write (`cpu_we`=1) with `cpu_addr[15]`=1 loads the control byte on that clock edge. Bits 4:0 of the byte are the program bank. For `cpu_addr` in `$8000-$BFFF`, `prg_addr` = {bank, `cpu_addr[13:0]`}. No other cycle changes the byte.
- R2: For `cpu_addr` in `$C000-$FFFF`, the bank field of `prg_addr` is always PRG_BANKS-1, whatever the control byte holds.
- R3: The program bank is taken modulo PRG_BANKS, which is a power of two. With 8 banks, a value of 29 selects bank 5.
- R4: Control bits 6:5 are the pattern bank. `chr_addr` = {bank, `ppu_addr[12:0]`}.
- R5: With variant code 0 or 2, the latched byte is `cpu_wdata & rom_rdata`. With codes 1 and 3, the latched byte is `cpu_wdata` unchanged.
- R6: With variant code 3, `mirror` leaves reset as vertical (01). After each load, control bit 7 selects vertical (1) or horizontal (00, when the bit is 0).
- R7: With another variant code and a single-screen header mode (10 or 11), `mirror` leaves reset equal to the header mode. After each load, bit 7 selects single-screen upper (11) or lower (10).
- R8: With another variant code and a horizontal (00) or vertical (01) header mode, `mirror` always equals the header mode and bit 7 has no effect.
- R9: A write with `cpu_addr` in `$6000-$7FFF` raises `prg_ram_we` in the same cycle when PRG_RAM_EN=1, and leaves the control byte unchanged.
- R10: After reset, the control byte is 0. Program bank 0 is seen at `$8000` and pattern bank 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| submapper | input | 4 | Board-variant code |
| hdr_mirror | input | 2 | Header mirroring mode (00 H, 01 V, 10 one-screen low, 11 one-screen high) |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| rom_rdata | input | 8 | Program-ROM byte at the addressed location |
| ppu_addr | input | 13 | Pattern-space address |
| prg_addr | output | 14+log2(PRG_BANKS) | Physical program-ROM address |
| prg_ram_we | output | 1 | Program-RAM write enable |
| chr_addr | output | 15 | Physical pattern-RAM address |
| mirror | output | 2 | Mirroring code |

## Verification
Address outputs follow `cpu_addr`/`ppu_addr` in the same cycle, and `prg_ram_we` follows the write strobe in the same cycle. Bank and mirroring results appear one rising edge after the write strobe is sampled. The driver therefore applies every write on a falling edge and removes the strobe on the next falling edge, which leaves exactly one rising edge in between. Only then does it set the probe addresses and queue the expected values. The monitor compares them 1 ns later, well away from any edge. The `prg_ram_we` check is queued while the strobe is still high, before its rising edge.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int CPU_AW = 16;
    localparam int DW     = 8;
    localparam int SUB_W  = 4;

    typedef enum logic [1:0] {
        MIR_HORZ   = 2'b00,
        MIR_VERT   = 2'b01,
        MIR_ONE_LO = 2'b10,
        MIR_ONE_HI = 2'b11
    } mirror_e;

    // Field layout of the control byte, decoded by the neighbours.
    typedef struct packed {
        logic       mir_sel;
        logic [1:0] chr_bank;
        logic [4:0] prg_bank;
    } ctrl_t;

endpackage

// File: rtl/mapper_ctrl_reg.sv
module mapper_ctrl_reg
    import mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SUB_W-1:0]     submapper_i,
    input  logic                 rom_win_i,
    input  logic                 cpu_we_i,
    input  logic [DW-1:0]        cpu_wdata_i,
    input  logic [DW-1:0]        rom_rdata_i,
    output ctrl_t                ctrl_o,
    output ctrl_t                ctrl_next_o,
    output logic                 load_o
);

    ctrl_t ctrl_d, ctrl_q;
    logic  load;
    logic  conflict;
    logic [DW-1:0] eff_data;

    always_comb begin
        load     = cpu_we_i && rom_win_i;
        conflict = (submapper_i == SUB_W'(0)) || (submapper_i == SUB_W'(2));
        eff_data = conflict ? (cpu_wdata_i & rom_rdata_i) : cpu_wdata_i;
        ctrl_d   = ctrl_q;
        if (load) begin
            ctrl_d = ctrl_t'(eff_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o      = ctrl_q;
    assign ctrl_next_o = ctrl_d;
    assign load_o      = load;

    // R1: the byte holds when no qualified write occurs
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we_i && rom_win_i) |=> $stable(ctrl_q));

    // R5: under a conflicting variant no bit set that the ROM held low
    p_conflict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && rom_win_i && (submapper_i == SUB_W'(0) || submapper_i == SUB_W'(2)))
        |=> ((ctrl_q & ~$past(rom_rdata_i)) == '0));

endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS  = 8,
    parameter bit PRG_RAM_EN = 1'b1,
    localparam int PRG_BW    = $clog2(PRG_BANKS),
    localparam int PRG_AW    = 14 + PRG_BW
) (
    input  logic [CPU_AW-1:0] cpu_addr_i,
    input  logic              cpu_we_i,
    input  logic [4:0]        prg_bank_i,
    output logic [PRG_AW-1:0] prg_addr_o,
    output logic              prg_ram_we_o
);

    localparam logic [4:0]        BANK_MASK = 5'(PRG_BANKS - 1);
    localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);

    logic [4:0]        bank_mod;
    logic [PRG_BW-1:0] bank_sel;

    always_comb begin
        bank_mod   = prg_bank_i & BANK_MASK;
        bank_sel   = cpu_addr_i[14] ? LAST_BANK : PRG_BW'(bank_mod);
        prg_addr_o = {bank_sel, cpu_addr_i[13:0]};
    end

    generate
        if (PRG_RAM_EN) begin : g_ram
            assign prg_ram_we_o = cpu_we_i && (cpu_addr_i[15:13] == 3'b011);
        end else begin : g_no_ram
            assign prg_ram_we_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map #(
    parameter int CHR_BANKS = 4,
    localparam int CHR_BW   = $clog2(CHR_BANKS),
    localparam int CHR_AW   = 13 + CHR_BW
) (
    input  logic [12:0]       ppu_addr_i,
    input  logic [1:0]        chr_bank_i,
    output logic [CHR_AW-1:0] chr_addr_o
);

    always_comb begin
        chr_addr_o = {CHR_BW'(chr_bank_i), ppu_addr_i};
    end

endmodule

// File: rtl/mapper_mirror.sv
module mapper_mirror
    import mapper_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUB_W-1:0] submapper_i,
    input  logic [1:0]       hdr_mirror_i,
    input  logic             load_i,
    input  logic             mir_bit_i,
    output logic [1:0]       mirror_o
);

    mirror_e mirror_d, mirror_q;
    mirror_e rst_val;
    logic    sub3;
    logic    sw_en;

    always_comb begin
        sub3     = (submapper_i == SUB_W'(3));
        sw_en    = sub3 || hdr_mirror_i[1];
        rst_val  = sub3 ? MIR_VERT : mirror_e'(hdr_mirror_i);
        mirror_d = mirror_q;
        if (load_i && sw_en) begin
            if (sub3) begin
                mirror_d = mir_bit_i ? MIR_VERT : MIR_HORZ;
            end else begin
                mirror_d = mir_bit_i ? MIR_ONE_HI : MIR_ONE_LO;
            end
        end
        mirror_o = sw_en ? mirror_q : hdr_mirror_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mirror_q <= rst_val;
        end else begin
            mirror_q <= mirror_d;
        end
    end

    // R6: a load under variant 3 yields H or V following the bit
    p_sub3_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && submapper_i == SUB_W'(3))
        |=> (mirror_o[1] == 1'b0 && mirror_o[0] == $past(mir_bit_i)));

    // R7: a load under a one-screen header yields a one-screen code
    p_one_screen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && submapper_i != SUB_W'(3) && hdr_mirror_i[1])
        |=> (mirror_o == {1'b1, $past(mir_bit_i)}));

endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS  = 8,
    parameter int CHR_BANKS  = 4,
    parameter bit PRG_RAM_EN = 1'b1,
    localparam int PRG_AW    = 14 + $clog2(PRG_BANKS),
    localparam int CHR_AW    = 13 + $clog2(CHR_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        submapper,
    input  logic [1:0]        hdr_mirror,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    input  logic [7:0]        rom_rdata,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_ram_we,
    output logic [CHR_AW-1:0] chr_addr,
    output logic [1:0]        mirror
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_next;
    logic  load;

    mapper_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .submapper_i (submapper),
        .rom_win_i   (cpu_addr[15]),
        .cpu_we_i    (cpu_we),
        .cpu_wdata_i (cpu_wdata),
        .rom_rdata_i (rom_rdata),
        .ctrl_o      (ctrl_q),
        .ctrl_next_o (ctrl_next),
        .load_o      (load)
    );

    mapper_prg_map #(
        .PRG_BANKS  (PRG_BANKS),
        .PRG_RAM_EN (PRG_RAM_EN)
    ) u_prg (
        .cpu_addr_i   (cpu_addr),
        .cpu_we_i     (cpu_we),
        .prg_bank_i   (ctrl_q.prg_bank),
        .prg_addr_o   (prg_addr),
        .prg_ram_we_o (prg_ram_we)
    );

    mapper_chr_map #(
        .CHR_BANKS (CHR_BANKS)
    ) u_chr (
        .ppu_addr_i (ppu_addr),
        .chr_bank_i (ctrl_q.chr_bank),
        .chr_addr_o (chr_addr)
    );

    mapper_mirror u_mir (
        .clk          (clk),
        .rst_n        (rst_n),
        .submapper_i  (submapper),
        .hdr_mirror_i (hdr_mirror),
        .load_i       (load),
        .mir_bit_i    (ctrl_next.mir_sel),
        .mirror_o     (mirror)
    );

    // R2: the top window always resolves to the last bank
    p_last_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b11)
        |-> (prg_addr[PRG_AW-1:14] == (PRG_AW-14)'(PRG_BANKS - 1)));

    // R9: a RAM-window write leaves the control byte alone
    p_ram_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prg_ram_we |=> $stable(ctrl_q));

    // R8: fixed header orientation is never altered by the register
    p_fixed_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (submapper != 4'd3 && !hdr_mirror[1] && load) |=> $stable(mirror));

endmodule

// File: tb/bank_mapper_top_tb_top.sv
`timescale 1ns/1ps
module bank_mapper_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  submapper = 4'd1;
    logic [1:0]  hdr_mirror = 2'b00;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_we = 1'b0;
    logic [7:0]  rom_rdata = 8'h00;
    logic [12:0] ppu_addr = 13'h0000;
    logic [16:0] prg_addr;
    logic        prg_ram_we;
    logic [14:0] chr_addr;
    logic [1:0]  mirror;

    always #2.5 clk = ~clk;

    bank_mapper_top dut_i (
        .clk(clk), .rst_n(rst_n), .submapper(submapper), .hdr_mirror(hdr_mirror),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .rom_rdata(rom_rdata), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .prg_ram_we(prg_ram_we), .chr_addr(chr_addr), .mirror(mirror)
    );

    typedef struct {
        string       tag;
        logic [16:0] prg;
        logic [14:0] chr;
        logic [1:0]  mir;
        logic        ram;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    int e_bank = 0;
    int e_chr  = 0;
    logic [1:0] e_mir = 2'b00;

    // Monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (prg_addr !== it.prg || chr_addr !== it.chr ||
                    mirror !== it.mir || prg_ram_we !== it.ram) begin
                    failures++;
                    $display("FAIL %s: prg=%h chr=%h mir=%b ram=%b expected prg=%h chr=%h mir=%b ram=%b",
                             it.tag, prg_addr, chr_addr, mirror, prg_ram_we,
                             it.prg, it.chr, it.mir, it.ram);
                end
            end
        end
    end

    task automatic push(input string tag, input logic [15:0] ca, input logic [12:0] pa,
                        input logic ram);
        item_t it;
        cpu_addr = ca;
        ppu_addr = pa;
        #1;
        it.tag = tag;
        it.prg = {(ca[14] ? 3'd7 : 3'(e_bank)), ca[13:0]};
        it.chr = {2'(e_chr), pa};
        it.mir = e_mir;
        it.ram = ram;
        q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic probe(input string tag);
        @(negedge clk);
        push(tag, 16'h8123, 13'h0ABC, 1'b0);
        push(tag, 16'hC456, 13'h1F00, 1'b0);
    endtask

    task automatic do_reset(input logic [3:0] sub, input logic [1:0] hdr);
        @(negedge clk);
        rst_n = 1'b0;
        submapper = sub;
        hdr_mirror = hdr;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_bank = 0;
        e_chr  = 0;
        e_mir  = (sub == 4'd3) ? 2'b01 : hdr;
    endtask

    // Driver: one write, expected model updated from the requirements
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
        logic [7:0] eff;
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        rom_rdata = r;
        cpu_we    = 1'b1;
        if (a[15:13] == 3'b011) push("R9", a, 13'h0000, 1'b1);
        @(negedge clk);
        cpu_we = 1'b0;
        eff = ((submapper == 4'd0) || (submapper == 4'd2)) ? (d & r) : d;
        if (a[15]) begin
            e_bank = int'(eff[4:0]) % 8;
            e_chr  = int'(eff[6:5]);
            if (submapper == 4'd3) e_mir = eff[7] ? 2'b01 : 2'b00;
            else if (hdr_mirror[1]) e_mir = eff[7] ? 2'b11 : 2'b10;
        end
    endtask

    initial begin
        do_reset(4'd1, 2'b00);
        probe("R10");                       // reset: bank 0, CHR 0, header H
        wr(16'h8000, 8'h05, 8'h00);
        probe("R1");                        // no conflict, bank 5
        wr(16'hC000, 8'h45, 8'hFF);
        probe("R4");                        // CHR bank 2, bank 5; R2 last bank
        wr(16'hFFFF, 8'h1D, 8'h00);
        probe("R3");                        // 29 wraps to 5
        wr(16'h9000, 8'h80, 8'h00);
        probe("R8");                        // H header stays H
        wr(16'h6000, 8'h07, 8'hFF);         // RAM window: R9
        probe("R9");                        // control byte unchanged
        wr(16'h4020, 8'h03, 8'hFF);
        probe("R1");                        // below $6000: no load

        do_reset(4'd1, 2'b01);
        wr(16'h8000, 8'h80, 8'h00);
        probe("R8");                        // V header stays V

        do_reset(4'd0, 2'b00);
        wr(16'h8000, 8'h05, 8'h00);
        probe("R5");                        // conflict forces bank 0
        wr(16'h8000, 8'h37, 8'h2C);
        probe("R5");                        // 0x24: bank 4, CHR 1

        do_reset(4'd2, 2'b00);
        wr(16'hA000, 8'hFF, 8'h63);
        probe("R5");                        // 0x63: bank 3, CHR 3

        do_reset(4'd3, 2'b00);
        probe("R6");                        // starts vertical
        wr(16'h8000, 8'h06, 8'h00);
        probe("R6");                        // no conflict; bit7=0 -> H
        wr(16'h8000, 8'h80, 8'h00);
        probe("R6");                        // bit7=1 -> V

        do_reset(4'd1, 2'b10);
        probe("R7");                        // starts lower
        wr(16'h8000, 8'h80, 8'h00);
        probe("R7");                        // upper
        wr(16'h8000, 8'h00, 8'h00);
        probe("R7");                        // lower

        do_reset(4'd0, 2'b11);
        probe("R7");                        // starts upper

        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule